// File: doc/BRIEF.md
# I2C Target Protocol Engine

This block is the bus-facing half of an I2C target device. It samples the open-drain clock and data lines on a 25 MHz system clock, cleans them up, and recognises bus conditions and bit edges. It then answers one fixed 7-bit device address and turns bus transfers into accesses on a simple register port (address, write strobe, write data, read data) that a separate register-map block serves. The engine drives the data line only by pulling it low; clock stretching is never used.

After an addressed write, the first byte is a register pointer. Every later byte is written at the pointer, and the pointer then steps forward. A read returns bytes starting at the pointer, which also steps forward once per byte. The pointer survives STOP and repeated START, so the usual register read is: write the pointer, issue a repeated START with the read bit set, then clock out as many bytes as needed. Every data byte the controller writes is acknowledged, even when the register map will drop it.

The controller is an eight-state machine. IDLE (bus free) and HOLD (ignoring traffic) both go to ADDR on START. ADDR shifts in the address byte. At the clock fall after the eighth bit it goes to ADDR_ACK on a match, or to HOLD otherwise. ADDR_ACK goes to WR_BYTE or RD_BYTE at the next fall, according to the direction bit. WR_BYTE goes to WR_ACK after eight bits, and WR_ACK returns to WR_BYTE. RD_BYTE goes to RD_ACK after eight bits. RD_ACK goes back to RD_BYTE when the controller acknowledged, or to HOLD when it did not. From any state, STOP leads to IDLE and START leads to ADDR.

Top module: `i2c_target_engine`

## Requirements
- R1: After reset the data line is released, no register write is issued, and the pointer is 0x00, so a read with no pointer write starts at register 0x00.
- R2: Only the address byte 0xAA/0xAB (device address 0x55, direction in bit 0, 1 = read) is acknowledged. Any other address is not acknowledged, and the engine neither drives the data line nor writes until the next START.
- R3: In a write transfer, the first byte after the address loads the pointer and produces no register write.
- R4: Each further written byte produces exactly one write strobe, carrying the pointer as address and the byte as data, and then the pointer increments.
- R5: Every written byte (pointer or data) is acknowledged, whatever address it targets.
- R6: Read bytes come out most significant bit first, from the pointer and then from successive addresses, one per controller acknowledge.
- R7: A not-acknowledge from the controller ends the read: the data line stays released until the next START or STOP.
- R8: The pointer keeps its value across STOP and across repeated START.
- R9: The pointer wraps from 0xFF to 0x00, for both reads and writes.
- R10: START or STOP seen while SCL is high aborts any byte in progress: no write comes from a partial byte, START restarts address reception and STOP returns to idle.
- R11: A clock pulse lasting one system clock is filtered out and does not count as a bit.
- R12: The engine changes its data-line drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (25 MHz in the target system) |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| reg_addr | output | 8 | Register port address (the pointer) |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data, valid with reg_wr |
| reg_rdata | input | 8 | Read data for reg_addr, combinational from the register map |

## Verification
The assertions assume a well-behaved controller: data changes only while SCL is low, except to form START and STOP, and START is never issued while the engine itself is pulling the data line low. They also assume that SCL low phases last longer than the filter delay, so a drive change settles before the next rising edge. The bench master changes data half a low phase after each SCL fall, and gives every repeated START and STOP the same half-phase spacing. It runs with half periods of 12, 31 and 125 system clocks. The only deliberate departures from a clean bus are a one-clock SCL pulse while SCL is low, and START/STOP placed in the middle of a byte.

// File: rtl/i2ct_pkg.sv
`timescale 1ns/1ps
package i2ct_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_HOLD
    } tgt_state_e;

endpackage

// File: rtl/i2ct_line_filter.sv
`timescale 1ns/1ps
// Synchroniser followed by a majority vote over recent samples.
module i2ct_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_TAPS   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    localparam int CW = $clog2(VOTE_TAPS + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [VOTE_TAPS-1:0]   taps_q;
    logic [CW-1:0]          votes;

    always_comb begin
        votes = '0;
        for (int i = 0; i < VOTE_TAPS; i++) begin
            votes = votes + CW'(taps_q[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            taps_q <= '1;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            taps_q <= {taps_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
            line_o <= (votes > CW'(VOTE_TAPS / 2));
        end
    end

    // R11
    filter_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&taps_q) |=> line_o);

    // R11
    filter_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (~|taps_q) |=> !line_o);

endmodule

// File: rtl/i2ct_bus_events.sv
`timescale 1ns/1ps
// Edge and bus-condition detection on the filtered lines.
module i2ct_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic cond_start,
    output logic cond_stop
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise   = scl_f & ~scl_q;
    assign scl_fall   = ~scl_f & scl_q;
    assign cond_start = scl_f & scl_q & sda_q & ~sda_f;
    assign cond_stop  = scl_f & scl_q & ~sda_q & sda_f;

endmodule

// File: rtl/i2c_target_engine.sv
`timescale 1ns/1ps
module i2c_target_engine
    import i2ct_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h55,
    parameter int         SYNC_STAGES = 2,
    parameter int         VOTE_TAPS   = 3,
    parameter int         PTR_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  reg_addr,
    output logic              reg_wr,
    output logic [BYTE_W-1:0] reg_wdata,
    input  logic [BYTE_W-1:0] reg_rdata
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

    // ---------------------------------------------------------------
    // Line conditioning: one filter per line (0 = clock, 1 = data)
    // ---------------------------------------------------------------
    logic [1:0] lines_raw;
    logic [1:0] lines_f;
    logic       scl_f;
    logic       sda_f;

    assign lines_raw = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        i2ct_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .VOTE_TAPS   (VOTE_TAPS)
        ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (lines_raw[g]),
            .line_o (lines_f[g])
        );
    end

    assign scl_f = lines_f[0];
    assign sda_f = lines_f[1];

    logic scl_rise;
    logic scl_fall;
    logic cond_start;
    logic cond_stop;

    i2ct_bus_events u_events (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_f      (scl_f),
        .sda_f      (sda_f),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .cond_start (cond_start),
        .cond_stop  (cond_stop)
    );

    // ---------------------------------------------------------------
    // State and datapath registers
    // ---------------------------------------------------------------
    tgt_state_e        state;
    tgt_state_e        nxt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txsh;
    logic [PTR_W-1:0]  ptr;
    logic              first_byte;
    logic              ack_seen;

    logic byte_end;
    logic addr_hit;
    logic ptr_load;
    logic ptr_inc;
    logic tx_load;
    logic tx_msb;

    assign byte_end = scl_fall && (bit_cnt == FULL_CNT);
    assign addr_hit = (shreg[BYTE_W-1:1] == DEV_ADDR);

    assign ptr_load = (state == ST_WR_BYTE) && byte_end && first_byte;
    assign tx_load  = scl_fall &&
                      (((state == ST_ADDR_ACK) && shreg[0]) ||
                       ((state == ST_RD_ACK) && ack_seen));
    assign ptr_inc  = tx_load ||
                      ((state == ST_WR_BYTE) && byte_end && !first_byte);

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_HOLD: nxt = state;
            ST_ADDR: begin
                if (byte_end) nxt = addr_hit ? ST_ADDR_ACK : ST_HOLD;
            end
            ST_ADDR_ACK: begin
                if (scl_fall) nxt = shreg[0] ? ST_RD_BYTE : ST_WR_BYTE;
            end
            ST_WR_BYTE: begin
                if (byte_end) nxt = ST_WR_ACK;
            end
            ST_WR_ACK: begin
                if (scl_fall) nxt = ST_WR_BYTE;
            end
            ST_RD_BYTE: begin
                if (scl_fall && (bit_cnt == LAST_BIT)) nxt = ST_RD_ACK;
            end
            ST_RD_ACK: begin
                if (scl_fall) nxt = ack_seen ? ST_RD_BYTE : ST_HOLD;
            end
            default: nxt = ST_IDLE;
        endcase
        if (cond_stop) begin
            nxt = ST_IDLE;
        end else if (cond_start) begin
            nxt = ST_ADDR;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Datapath: bit counting, shifting, pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            txsh       <= '0;
            ptr        <= '0;
            first_byte <= 1'b0;
            ack_seen   <= 1'b0;
        end else begin
            if (cond_start || cond_stop) begin
                bit_cnt <= '0;
            end else begin
                if (((state == ST_ADDR) || (state == ST_WR_BYTE)) &&
                    scl_rise && (bit_cnt < FULL_CNT)) begin
                    shreg   <= {shreg[BYTE_W-2:0], sda_f};
                    bit_cnt <= bit_cnt + CNT_W'(1);
                end
                if (((state == ST_ADDR_ACK) || (state == ST_WR_ACK)) && scl_fall) begin
                    bit_cnt <= '0;
                end
                if ((state == ST_ADDR) && byte_end) begin
                    first_byte <= 1'b1;
                end
                if ((state == ST_RD_BYTE) && scl_fall) begin
                    if (bit_cnt == LAST_BIT) begin
                        bit_cnt <= '0;
                    end else begin
                        bit_cnt <= bit_cnt + CNT_W'(1);
                        txsh    <= {txsh[BYTE_W-2:0], 1'b0};
                    end
                end
                if ((state == ST_RD_ACK) && scl_rise) begin
                    ack_seen <= ~sda_f;
                end
            end
            if (ptr_load) begin
                ptr        <= PTR_W'(shreg);
                first_byte <= 1'b0;
            end else if (ptr_inc) begin
                ptr <= ptr + PTR_W'(1);
            end
            if (tx_load) begin
                txsh <= reg_rdata;
            end
        end
    end

    // Data bit that will be on the line after this cycle
    always_comb begin
        if (tx_load) begin
            tx_msb = reg_rdata[BYTE_W-1];
        end else if ((state == ST_RD_BYTE) && scl_fall) begin
            tx_msb = txsh[BYTE_W-2];
        end else begin
            tx_msb = txsh[BYTE_W-1];
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe <= 1'b0;
        end else begin
            unique case (nxt)
                ST_ADDR_ACK, ST_WR_ACK: sda_oe <= 1'b1;
                ST_RD_BYTE:             sda_oe <= ~tx_msb;
                default:                sda_oe <= 1'b0;
            endcase
        end
    end

    assign reg_addr  = ptr;
    assign reg_wdata = shreg;
    assign reg_wr    = (state == ST_WR_BYTE) && byte_end && !first_byte;

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    // R2
    addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK) |-> (shreg[BYTE_W-1:1] == DEV_ADDR));

    // R5
    wr_then_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> ((state == ST_WR_ACK) && sda_oe));

    // R4
    wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (ptr == $past(ptr) + PTR_W'(1)));

    // R7
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HOLD) || (state == ST_IDLE)) |-> !sda_oe);

    // R9
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc && (ptr == '1)) |=> (ptr == '0));

    // R10
    start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cond_start |=> ((state == ST_ADDR) && (bit_cnt == '0) && !reg_wr));

    // R10
    stop_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cond_stop |=> ((state == ST_IDLE) && !sda_oe));

    // R12
    sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f) && !$past(cond_start) && !$past(cond_stop))
            |-> $stable(sda_oe));

endmodule

// File: tb/i2c_target_engine_bench.sv
`timescale 1ns/1ps
module i2c_target_engine_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [7:0] reg_addr;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       sda_line;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_target_engine u_i2c_target_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    // Register map stand-in: 0x00-0x07 writable, 0x08-0x0F fixed, 0xF8-0xFF id, rest 0
    logic [7:0] bmem [0:7];
    always_comb begin
        if (reg_addr < 8'h08)       reg_rdata = bmem[reg_addr[2:0]];
        else if (reg_addr < 8'h10)  reg_rdata = 8'hC0 ^ reg_addr;
        else if (reg_addr >= 8'hF8) reg_rdata = 8'h5A + reg_addr;
        else                        reg_rdata = 8'h00;
    end
    always @(posedge clk) begin
        if (reg_wr && (reg_addr < 8'h08)) bmem[reg_addr[2:0]] <= reg_wdata;
    end

    // Reference model
    logic [7:0]  mdl [0:7];
    logic [7:0]  exp_ptr = 8'h00;
    logic [15:0] exp_wr [$];
    int          n_tests = 0;
    int          n_fail  = 0;
    int          hp      = 12;
    bit          silent  = 1'b0;
    bit          done    = 1'b0;
    int          silent_viol = 0;
    int          hold_viol   = 0;
    logic        prev_scl = 1'b1;
    logic        prev_oe  = 1'b0;

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        if (a < 8'h08)       return mdl[a[2:0]];
        else if (a < 8'h10)  return 8'hC0 ^ a;
        else if (a >= 8'hF8) return 8'h5A + a;
        else                 return 8'h00;
    endfunction

    task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Per-clock comparison of the register port and the data-line drive
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr) begin
                n_tests++;
                if (exp_wr.size() == 0) begin
                    n_fail++;
                    $display("FAIL R4 unexpected write actual=%02h:%02h expected=none",
                             reg_addr, reg_wdata);
                end else begin
                    logic [15:0] e;
                    e = exp_wr.pop_front();
                    if ({reg_addr, reg_wdata} !== e) begin
                        n_fail++;
                        $display("FAIL R4 write actual=%02h:%02h expected=%02h:%02h",
                                 reg_addr, reg_wdata, e[15:8], e[7:0]);
                    end
                end
            end
            if (silent && sda_oe) silent_viol++;
            if (scl_m && prev_scl && (sda_oe !== prev_oe)) hold_viol++;
            prev_scl <= scl_m;
            prev_oe  <= sda_oe;
        end
    end

    // Bus master
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b0; tick(hp);
        scl_m = 1'b0;
    endtask

    task automatic bus_restart;
        tick(hp / 2); sda_m = 1'b1; tick(hp);
        scl_m = 1'b1; tick(hp);
        sda_m = 1'b0; tick(hp);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop;
        tick(hp / 2); sda_m = 1'b0; tick(hp);
        scl_m = 1'b1; tick(hp);
        sda_m = 1'b1; tick(2 * hp);
    endtask

    task automatic send_bit(input logic b);
        tick(hp / 2); sda_m = b; tick(hp - hp / 2);
        scl_m = 1'b1; tick(hp);
        scl_m = 1'b0;
    endtask

    task automatic recv_bit(output logic b);
        tick(hp / 2); sda_m = 1'b1; tick(hp - hp / 2);
        scl_m = 1'b1; tick(hp / 2);
        b = sda_line; tick(hp - hp / 2);
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(a);
        ack = ~a;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(~give_ack);
    endtask

    task automatic addr(input logic rd, input string tag);
        logic ack;
        send_byte({7'h55, rd}, ack);
        chk8(tag, {7'd0, ack}, 8'h01);
    endtask

    task automatic set_ptr(input logic [7:0] p);
        logic ack;
        send_byte(p, ack);
        chk8("R5 pointer byte ack", {7'd0, ack}, 8'h01);
        exp_ptr = p;
    endtask

    task automatic wr_data(input logic [7:0] d, input string tag);
        logic ack;
        exp_wr.push_back({exp_ptr, d});
        if (exp_ptr < 8'h08) mdl[exp_ptr[2:0]] = d;
        send_byte(d, ack);
        chk8(tag, {7'd0, ack}, 8'h01);
        exp_ptr = exp_ptr + 8'h01;
    endtask

    task automatic rd_data(input logic last, input string tag);
        logic [7:0] d;
        recv_byte(d, ~last);
        chk8(tag, d, exp_rd(exp_ptr));
        exp_ptr = exp_ptr + 8'h01;
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        logic       ack;
        logic [7:0] d;
        for (int i = 0; i < 8; i++) begin
            mdl[i]  = 8'h81 ^ (8'(i) * 8'h13);
            bmem[i] = 8'h81 ^ (8'(i) * 8'h13);
        end
        tick(10);
        rst_n = 1'b1;
        tick(10);
        // R1 reset state
        chk8("R1 sda released after reset", {7'd0, sda_oe}, 8'h00);
        chk8("R1 no write after reset", {7'd0, reg_wr}, 8'h00);

        // R1/R6: read from pointer 0 without a pointer write; R7 after NACK
        hp = 12;
        bus_start; addr(1'b1, "R2 read address ack");
        rd_data(1'b0, "R1 first read from 0x00");
        rd_data(1'b1, "R6 second read byte");
        silent = 1'b1;
        recv_byte(d, 1'b0);
        chk8("R7 line released after NACK", d, 8'hFF);
        bus_stop;
        silent = 1'b0;

        // R3/R4/R5 bulk write
        bus_start; addr(1'b0, "R2 write address ack");
        set_ptr(8'h02);
        wr_data(8'h5C, "R5 data ack 0x02");
        wr_data(8'h3E, "R5 data ack 0x03");
        wr_data(8'h90, "R5 data ack 0x04");
        bus_stop;

        // R5 writes to read-only and unmapped targets still acknowledged
        bus_start; addr(1'b0, "R2 write address ack");
        set_ptr(8'h0E);
        wr_data(8'h11, "R5 ack read-only 0x0E");
        wr_data(8'h22, "R5 ack read-only 0x0F");
        wr_data(8'h33, "R5 ack unmapped 0x10");
        bus_stop;

        // R6/R8 read through repeated START, then continue after STOP
        bus_start; addr(1'b0, "R2 write address ack");
        set_ptr(8'h01);
        bus_restart; addr(1'b1, "R8 read address after restart");
        for (int i = 0; i < 4; i++) rd_data(1'b0, "R6 sequential read");
        rd_data(1'b1, "R6 sequential read last");
        bus_stop;
        bus_start; addr(1'b1, "R2 read address ack");
        rd_data(1'b1, "R8 pointer kept across STOP");
        bus_stop;

        // R9 wrap on write and read
        bus_start; addr(1'b0, "R2 write address ack");
        set_ptr(8'hFF);
        wr_data(8'hA1, "R9 write at 0xFF");
        wr_data(8'hB2, "R9 write wraps to 0x00");
        bus_stop;
        bus_start; addr(1'b0, "R2 write address ack");
        set_ptr(8'hFE);
        bus_restart; addr(1'b1, "R2 read address ack");
        rd_data(1'b0, "R9 read 0xFE");
        rd_data(1'b0, "R9 read 0xFF");
        rd_data(1'b0, "R9 read wrapped 0x00");
        rd_data(1'b1, "R9 read 0x01");
        bus_stop;

        // R2 foreign address ignored
        silent = 1'b1;
        bus_start;
        send_byte(8'h54, ack);
        chk8("R2 foreign address not acked", {7'd0, ack}, 8'h00);
        send_byte(8'h01, ack);
        chk8("R2 foreign data not acked", {7'd0, ack}, 8'h00);
        bus_stop;
        silent = 1'b0;

        // R10 START and STOP in the middle of a byte
        bus_start; addr(1'b0, "R2 write address ack");
        set_ptr(8'h03);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_restart; addr(1'b0, "R10 address after aborted byte");
        set_ptr(8'h04);
        wr_data(8'h77, "R10 write after restart");
        bus_stop;
        bus_start; addr(1'b0, "R2 write address ack");
        set_ptr(8'h06);
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        bus_stop;
        bus_start; addr(1'b1, "R2 read address ack");
        rd_data(1'b1, "R10 no write from partial byte, read 0x06");
        bus_stop;

        // R11 one-clock glitch on SCL inside a byte
        bus_start; addr(1'b0, "R2 write address ack");
        set_ptr(8'h07);
        exp_wr.push_back({8'h07, 8'h6D});
        mdl[7] = 8'h6D;
        for (int i = 7; i >= 4; i--) send_bit(d_const(i));
        tick(3); scl_m = 1'b1; tick(1); scl_m = 1'b0;
        for (int i = 3; i >= 0; i--) send_bit(d_const(i));
        recv_bit(d[0]);
        chk8("R11 byte with glitch acked", {7'd0, ~d[0]}, 8'h01);
        exp_ptr = 8'h08;
        bus_restart; addr(1'b0, "R2 write address ack");
        set_ptr(8'h07);
        bus_restart; addr(1'b1, "R2 read address ack");
        rd_data(1'b1, "R11 glitch did not add a bit");
        bus_stop;

        // Slower bus rates
        hp = 31;
        bus_start; addr(1'b0, "R2 write address ack");
        set_ptr(8'h00);
        wr_data(8'h42, "R4 write at mid rate");
        bus_restart; addr(1'b1, "R2 read address ack");
        rd_data(1'b1, "R6 read at mid rate");
        bus_stop;
        hp = 125;
        bus_start; addr(1'b0, "R2 write address ack");
        set_ptr(8'h08);
        bus_restart; addr(1'b1, "R2 read address ack");
        rd_data(1'b0, "R6 read 0x08 at low rate");
        rd_data(1'b1, "R6 read 0x09 at low rate");
        bus_stop;

        chk8("R4 all expected writes seen", 8'(exp_wr.size()), 8'h00);
        chk8("R2 no drive while not addressed", 8'(silent_viol), 8'h00);
        chk8("R12 drive changed while SCL high", 8'(hold_viol), 8'h00);
        done = 1'b1;
        summary;
        $finish;
    end

    function automatic logic d_const(input int i);
        logic [7:0] v;
        v = 8'h6D;
        return v[i];
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R6 watchdog actual=hung expected=finished");
            summary;
            $finish;
        end
    end

endmodule